// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block collects change events from a bank of 32 input pins and turns them into one interrupt request. Each pin input is brought into the clock domain by a synchronizer. It then passes through a glitch filter, which software can switch on or off for each pin. The filtered level is compared with its value one cycle earlier. Any difference, rising or falling, sets that pin's pending bit.

Software sees the block through a small memory-mapped register bus. It unmasks pins through an enable register and masks them through a separate disable register, so it never needs a read-modify-write. The filters are controlled the same way. Reading the status register returns every pending bit and clears them all, which acknowledges the interrupt. The single interrupt output is high while any pending pin is also unmasked.

Top module: `pin_irq_ctrl`

## Requirements
- R1: A rising or a falling change of a pin's filtered level sets that pin's pending bit. No other event sets it, and there is no edge or level selection.
- R2: A read of byte offset 0x0C (status) returns the pending bits, one bit per pin, with bit n for pin n. The read clears all pending bits.
- R3: Writing to offset 0x00 sets the mask bits wherever the written word holds a 1. Writing to offset 0x04 clears them wherever it holds a 1. Bits written as 0 keep their value. Offset 0x08 reads the mask back, with 1 meaning unmasked.
- R4: `irq_o` is high exactly when at least one pin has both its pending bit and its mask bit set.
- R5: Writing 1s to offset 0x10 turns on the glitch filters of the pins concerned. Writing 1s to offset 0x14 turns them off. Offset 0x18 reads back which filters are on.
- R6: A pin that changes while masked still becomes pending. Unmasking it later raises `irq_o` if the bit has not been read in the meantime.
- R7: When a pin's filter is on, a new level passes only after it has been stable for two consecutive cycles. A one-cycle pulse then leaves no pending bit. A pulse of three cycles gives a pending bit. A pin without a filter records a one-cycle pulse.
- R8: If a pin's edge falls in the same cycle as a status read, that pin's pending bit is still set after the read.
- R9: A pin that is already high when reset is released does not produce a pending bit.
- R10: After reset the mask reads 0, the filter register reads 0, the status reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin levels |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each bus access lasts exactly one cycle and that reads return the register value from the cycle of the strobe. They also assume that pin levels can change at any cycle, but only through the synchronizer. The bench drives pins and bus signals only on falling clock edges and lets `sel_i` pulse for a single cycle. After each pin change it waits long enough for the synchronizer and filter to settle before reading. The one exception is the race case, where the status read is placed on the cycle in which the edge reaches the pending register.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_IRQ_SET  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_IRQ_CLR  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_IRQ_MASK = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_FLT_SET  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_FLT_CLR  = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_FLT_STAT = 5'h18;

  typedef enum logic [2:0] {
    REG_NONE, REG_IRQ_SET, REG_IRQ_CLR, REG_IRQ_MASK,
    REG_STATUS, REG_FLT_SET, REG_FLT_CLR, REG_FLT_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_IRQ_SET:  return REG_IRQ_SET;
      OFF_IRQ_CLR:  return REG_IRQ_CLR;
      OFF_IRQ_MASK: return REG_IRQ_MASK;
      OFF_STATUS:   return REG_STATUS;
      OFF_FLT_SET:  return REG_FLT_SET;
      OFF_FLT_CLR:  return REG_FLT_CLR;
      OFF_FLT_STAT: return REG_FLT_STAT;
      default:      return REG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] hist_q, out_q;

  for (genvar p = 0; p < W; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q[p] <= 1'b0;
        out_q[p]  <= 1'b0;
      end else begin
        hist_q[p] <= lvl_i[p];
        // filtered pins accept a level only once it matched the previous cycle
        if (!en_i[p] || (lvl_i[p] == hist_q[p])) out_q[p] <= lvl_i[p];
      end
    end
  end

  assign lvl_o = out_q;
endmodule

// File: rtl/pin_edge_latch.sv
module pin_edge_latch #(
  parameter int unsigned W     = 32,
  parameter int unsigned PRIME = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         clr_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] pend_o
);
  localparam int unsigned CNT_W = $clog2(PRIME + 1);

  logic [CNT_W-1:0] prime_cnt_q;
  logic             primed;
  logic [W-1:0]     last_q, pend_q;

  assign primed = (prime_cnt_q == CNT_W'(PRIME));

  // hold off edges until the pipeline carries real pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prime_cnt_q <= '0;
    else if (!primed) prime_cnt_q <= prime_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else last_q <= lvl_i;
  end

  assign edge_o = primed ? (lvl_i ^ last_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= (pend_q & ~{W{clr_i}}) | edge_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      flt_o,
  output logic              stat_rd_o
);
  reg_sel_e     rsel;
  logic         wr_en, rd_en;
  logic [W-1:0] mask_q, flt_q, rdata_q;

  assign rsel      = decode_addr(addr_i);
  assign wr_en     = sel_i & wr_i;
  assign rd_en     = sel_i & ~wr_i;
  assign stat_rd_o = rd_en && (rsel == REG_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      flt_q  <= '0;
    end else if (wr_en) begin
      case (rsel)
        REG_IRQ_SET: mask_q <= mask_q | wdata_i;
        REG_IRQ_CLR: mask_q <= mask_q & ~wdata_i;
        REG_FLT_SET: flt_q  <= flt_q | wdata_i;
        REG_FLT_CLR: flt_q  <= flt_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en) begin
      case (rsel)
        REG_IRQ_MASK: rdata_q <= mask_q;
        REG_STATUS:   rdata_q <= pend_i;
        REG_FLT_STAT: rdata_q <= flt_q;
        default:      rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign flt_o   = flt_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o
);
  localparam int unsigned PRIME = SYNC_STAGES + 2;

  logic [NUM_PINS-1:0] sync_lvl, filt_lvl, edge_v, pend_q, mask_q, flt_q;
  logic                stat_rd;

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_lvl)
  );

  pin_deglitch #(.W(NUM_PINS)) i_deglitch (
    .clk_i, .rst_ni, .lvl_i(sync_lvl), .en_i(flt_q), .lvl_o(filt_lvl)
  );

  pin_edge_latch #(.W(NUM_PINS), .PRIME(PRIME)) i_edge (
    .clk_i, .rst_ni, .lvl_i(filt_lvl), .clr_i(stat_rd),
    .edge_o(edge_v), .pend_o(pend_q)
  );

  pin_irq_regs #(.W(NUM_PINS)) i_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i,
    .pend_i(pend_q), .rdata_o, .mask_o(mask_q), .flt_o(flt_q),
    .stat_rd_o(stat_rd)
  );

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rdata_o,
  input logic              irq_o,
  input logic [W-1:0]      mask_q,
  input logic [W-1:0]      pend_q,
  input logic [W-1:0]      edge_v,
  input logic              stat_rd
);
  a_r2_read_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> (rdata_o == $past(pend_q)));

  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> ((pend_q & ~$past(edge_v)) == '0));

  a_r8_race_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> ((pend_q & $past(edge_v)) == $past(edge_v)));

  a_r1_only_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd |=> (pend_q == ($past(pend_q) | $past(edge_v))));

  a_r6_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r3_enable_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == OFF_IRQ_SET) |=>
      ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  a_r3_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == OFF_IRQ_CLR) |=> ((mask_q & $past(wdata_i)) == '0));

  a_r4_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

bind pin_irq_ctrl pin_irq_chk #(.W(NUM_PINS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .mask_q(mask_q),
  .pend_q(pend_q), .edge_v(edge_v), .stat_rd(stat_rd)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  import pin_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  pin_irq_ctrl i_pin_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed { logic [31:0] pins; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{32'h0000_0001, 32'h0000_0001}, '{32'h8000_0001, 32'h8000_0000},
    '{32'hFFFF_0000, 32'h7FFF_0001}, '{32'h0000_FFFF, 32'hFFFF_FFFF},
    '{32'h0000_FFFF, 32'h0000_0000}, '{32'hA5A5_5A5A, 32'hA5A5_A5A5},
    '{32'h0000_0000, 32'hA5A5_5A5A}, '{32'h1234_5678, 32'h1234_5678}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9, R10: reset with some pins already high
    pins = 32'hF0F0_0000;
    idle(3); rst_n = 1'b1; idle(8);
    check("R10 irq", {31'b0, irq}, 32'h0);
    bus_rd(OFF_IRQ_MASK, v); check("R10 mask", v, 32'h0);
    bus_rd(OFF_FLT_STAT, v); check("R10 filter", v, 32'h0);
    bus_rd(OFF_STATUS, v);   check("R9 no false edge", v, 32'h0);

    // R1: falling edges
    @(negedge clk); pins = 32'h0; idle(6);
    bus_rd(OFF_STATUS, v); check("R1 falling", v, 32'hF0F0_0000);
    bus_rd(OFF_STATUS, v); check("R2 cleared", v, 32'h0);

    // R3, R4: vector table with all pins unmasked
    bus_wr(OFF_IRQ_SET, 32'hFFFF_FFFF);
    foreach (VECS[i]) begin
      @(negedge clk); pins = VECS[i].pins; idle(6);
      check("R4 irq level", {31'b0, irq}, {31'b0, VECS[i].exp != 0});
      bus_rd(OFF_STATUS, v); check("R1 table", v, VECS[i].exp);
      check("R2 irq after read", {31'b0, irq}, 32'h0);
    end

    // R3: partial disable
    bus_wr(OFF_IRQ_CLR, 32'h0000_00FF);
    bus_rd(OFF_IRQ_MASK, v); check("R3 mask", v, 32'hFFFF_FF00);
    bus_wr(OFF_IRQ_SET, 32'h0000_0000);
    bus_rd(OFF_IRQ_MASK, v); check("R3 zero write", v, 32'hFFFF_FF00);

    // R6: masked pin still pends
    @(negedge clk); pins[0] = ~pins[0]; idle(6);
    check("R6 masked irq low", {31'b0, irq}, 32'h0);
    bus_wr(OFF_IRQ_SET, 32'h0000_0001);
    check("R6 unmask irq high", {31'b0, irq}, 32'h1);
    bus_rd(OFF_STATUS, v); check("R6 status", v, 32'h0000_0001);

    // R5, R7: filter on pin 8, none on pin 9
    pins = 32'h0; idle(6); bus_rd(OFF_STATUS, v);
    bus_wr(OFF_FLT_SET, 32'h0000_0100);
    bus_rd(OFF_FLT_STAT, v); check("R5 filter on", v, 32'h0000_0100);
    @(negedge clk); pins = 32'h0000_0300;
    @(negedge clk); pins = 32'h0;
    idle(8);
    bus_rd(OFF_STATUS, v); check("R7 short pulse", v, 32'h0000_0200);
    @(negedge clk); pins = 32'h0000_0100; idle(3);
    pins = 32'h0; idle(8);
    bus_rd(OFF_STATUS, v); check("R7 long pulse", v, 32'h0000_0100);
    bus_wr(OFF_FLT_CLR, 32'h0000_0100);
    bus_rd(OFF_FLT_STAT, v); check("R5 filter off", v, 32'h0);

    // R8: edge coincides with status read
    @(negedge clk); pins = 32'h0000_0400;
    idle(2);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = OFF_STATUS;
    @(negedge clk); sel = 1'b0;
    idle(4);
    bus_rd(OFF_STATUS, v); check("R8 race kept", v, 32'h0000_0400);

    // R4: fully masked
    bus_wr(OFF_IRQ_CLR, 32'hFFFF_FFFF);
    @(negedge clk); pins = 32'h0000_F000; idle(6);
    check("R4 masked irq", {31'b0, irq}, 32'h0);
    bus_rd(OFF_STATUS, v); check("R4 pending kept", v, 32'h0000_F400);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule